// File: doc/BRIEF.md
# DRAM Row Retirement Sequencer

When a memory error points at a DRAM row, every system page that the row feeds has to be taken out of service. This block walks through all column values of the failing address. For each column it asks an external address translator for the system address behind it. Each page that comes back healthy and still in use gets a retire command.

A row has a partner row that differs from it in one row bit. After the first sweep the sequencer flips that bit and runs the whole column sweep again. A single start pulse loads the error address. The block then works on its own and raises done for one cycle when the second sweep has finished.

The translation and the record keeping for retired pages sit outside the block. The block only orders the requests, filters the responses and holds each retire command until the consumer accepts it.

Top module: `row_retire_seq`

## Requirements
- R1: After reset, req_valid_o, ret_valid_o and done_o are low, and the block waits for a start pulse.
- R2: Each sweep issues one translation request per column value, in ascending order from 0 to 2^COL_W-1. Each request address is the latched error address with bits [COL_LSB+COL_W-1:COL_LSB] (default [5:1]) replaced by the column value. All other bits are unchanged.
- R3: A response with rsp_fail_i high produces no retire command for that column.
- R4: A response with rsp_online_i low produces no retire command for that column.
- R5: A response with rsp_poisoned_i high produces no retire command for that column.
- R6: Any other response produces exactly one retire command. Its ret_pfn_o is rsp_sys_addr_i shifted right by PAGE_SHIFT (12). Retire commands leave the block in column order.
- R7: The second sweep uses the error address with bit FLIP_BIT (default 23) inverted, so each run makes 2*2^COL_W requests in total.
- R8: done_o is high for exactly one cycle, after the last column of the second sweep has been handled, and never at any other time.
- R9: start_i has no effect unless the block is idle. This includes the cycle in which done_o is high.
- R10: req_valid_o and req_addr_o stay stable until req_ready_i accepts the request. ret_valid_o and ret_pfn_o stay stable until ret_ready_i accepts the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse, sampled only while idle |
| err_addr_i | input | ADDR_W | Error address latched on start |
| req_valid_o | output | 1 | Translation request valid |
| req_ready_i | input | 1 | Translator accepts the request |
| req_addr_o | output | ADDR_W | Error address with the current column (and the partner-row flip) |
| rsp_valid_i | input | 1 | Translation response valid |
| rsp_fail_i | input | 1 | Translation failed |
| rsp_online_i | input | 1 | Page is online |
| rsp_poisoned_i | input | 1 | Page is already retired |
| rsp_sys_addr_i | input | SYS_W | Translated system address |
| ret_valid_o | output | 1 | Retire command valid |
| ret_ready_i | input | 1 | Retire command accepted |
| ret_pfn_o | output | SYS_W-PAGE_SHIFT | Page frame number to retire |
| done_o | output | 1 | One-cycle pulse when both sweeps are complete |

## Verification
Two events can meet in one cycle: a new start pulse and the end of a run, where done_o is high. The bench provokes this by driving start_i in exactly the cycle it sees done_o. It then checks that no translation request appears during the following cycles, and that a later start taken while idle runs normally. The bench also pulses start_i in the middle of a sweep with a different address. It judges the outcome by comparing every later request address against the model built from the first address. Randomized ready signals and response delays let the retire handshake stall while the column counter is waiting, so both hold rules are exercised.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

    typedef enum logic [2:0] {
        S_IDLE   = 3'd0,
        S_REQ    = 3'd1,
        S_WAIT   = 3'd2,
        S_RETIRE = 3'd3,
        S_NEXT   = 3'd4,
        S_FLIP   = 3'd5,
        S_DONE   = 3'd6
    } seq_state_e;

endpackage

// File: rtl/rrs_col_addr.sv
// Builds the request address: column field replaced, partner-row bit optionally inverted.
module rrs_col_addr #(
    parameter int ADDR_W   = 32,
    parameter int COL_LSB  = 1,
    parameter int COL_W    = 5,
    parameter int FLIP_BIT = 23
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [COL_W-1:0]  col_i,
    input  logic              partner_i,
    output logic [ADDR_W-1:0] addr_o
);
    localparam int COL_MSB = COL_LSB + COL_W - 1;

    for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
        if (b >= COL_LSB && b <= COL_MSB) begin : g_col
            assign addr_o[b] = col_i[b - COL_LSB];
        end else if (b == FLIP_BIT) begin : g_flip
            assign addr_o[b] = base_i[b] ^ partner_i;
        end else begin : g_keep
            assign addr_o[b] = base_i[b];
        end
    end

endmodule

// File: rtl/rrs_page_filter.sv
// Decides whether a translated page is to be retired and extracts its frame number.
module rrs_page_filter #(
    parameter int SYS_W      = 48,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
    input  logic             fail_i,
    input  logic             online_i,
    input  logic             poisoned_i,
    input  logic [SYS_W-1:0] sys_addr_i,
    output logic             take_o,
    output logic [PFN_W-1:0] pfn_o
);
    logic unused_offset;

    assign take_o        = !fail_i && online_i && !poisoned_i;
    assign pfn_o         = sys_addr_i[SYS_W-1:PAGE_SHIFT];
    assign unused_offset = ^sys_addr_i[PAGE_SHIFT-1:0];

endmodule

// File: rtl/row_retire_seq.sv
module row_retire_seq
    import rrs_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int COL_LSB    = 1,
    parameter int COL_W      = 5,
    parameter int FLIP_BIT   = 23,
    parameter int SYS_W      = 48,
    parameter int PAGE_SHIFT = 12,
    localparam int PFN_W     = SYS_W - PAGE_SHIFT
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] err_addr_i,
    output logic              req_valid_o,
    input  logic              req_ready_i,
    output logic [ADDR_W-1:0] req_addr_o,
    input  logic              rsp_valid_i,
    input  logic              rsp_fail_i,
    input  logic              rsp_online_i,
    input  logic              rsp_poisoned_i,
    input  logic [SYS_W-1:0]  rsp_sys_addr_i,
    output logic              ret_valid_o,
    input  logic              ret_ready_i,
    output logic [PFN_W-1:0]  ret_pfn_o,
    output logic              done_o
);

    typedef struct packed {
        seq_state_e        st;
        logic [ADDR_W-1:0] base;
        logic [COL_W-1:0]  col;
        logic              partner;
        logic [PFN_W-1:0]  pfn;
    } regs_t;

    regs_t            r_d, r_q;
    logic             take;
    logic [PFN_W-1:0] rsp_pfn;

    rrs_col_addr #(
        .ADDR_W  (ADDR_W),
        .COL_LSB (COL_LSB),
        .COL_W   (COL_W),
        .FLIP_BIT(FLIP_BIT)
    ) i_col_addr (
        .base_i   (r_q.base),
        .col_i    (r_q.col),
        .partner_i(r_q.partner),
        .addr_o   (req_addr_o)
    );

    rrs_page_filter #(
        .SYS_W     (SYS_W),
        .PAGE_SHIFT(PAGE_SHIFT)
    ) i_filter (
        .fail_i    (rsp_fail_i),
        .online_i  (rsp_online_i),
        .poisoned_i(rsp_poisoned_i),
        .sys_addr_i(rsp_sys_addr_i),
        .take_o    (take),
        .pfn_o     (rsp_pfn)
    );

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            S_IDLE: begin
                if (start_i) begin
                    r_d.base    = err_addr_i;
                    r_d.col     = '0;
                    r_d.partner = 1'b0;
                    r_d.st      = S_REQ;
                end
            end
            S_REQ: begin
                if (req_ready_i) r_d.st = S_WAIT;
            end
            S_WAIT: begin
                if (rsp_valid_i) begin
                    if (take) begin
                        r_d.pfn = rsp_pfn;
                        r_d.st  = S_RETIRE;
                    end else begin
                        r_d.st  = S_NEXT;
                    end
                end
            end
            S_RETIRE: begin
                if (ret_ready_i) r_d.st = S_NEXT;
            end
            S_NEXT: begin
                if (&r_q.col) begin
                    r_d.st = r_q.partner ? S_DONE : S_FLIP;
                end else begin
                    r_d.col = r_q.col + 1'b1;
                    r_d.st  = S_REQ;
                end
            end
            S_FLIP: begin
                r_d.col     = '0;
                r_d.partner = 1'b1;
                r_d.st      = S_REQ;
            end
            S_DONE: begin
                r_d.st = S_IDLE;
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st      <= S_IDLE;
            r_q.base    <= '0;
            r_q.col     <= '0;
            r_q.partner <= 1'b0;
            r_q.pfn     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign req_valid_o = (r_q.st == S_REQ);
    assign ret_valid_o = (r_q.st == S_RETIRE);
    assign ret_pfn_o   = r_q.pfn;
    assign done_o      = (r_q.st == S_DONE);

    // R10: request held until accepted
    a_r10_req_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_valid_o && !req_ready_i |=> req_valid_o && $stable(req_addr_o));

    // R10: retire command held until accepted
    a_r10_ret_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ret_valid_o && !ret_ready_i |=> ret_valid_o && $stable(ret_pfn_o));

    // R3: failed translation never leads to a retire command
    a_r3_fail_skips: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_WAIT) && rsp_valid_i && rsp_fail_i |=> !ret_valid_o);

    // R5: poisoned page never leads to a retire command
    a_r5_poison_skips: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_WAIT) && rsp_valid_i && rsp_poisoned_i |=> !ret_valid_o);

    // R7: the partner sweep inverts the chosen row bit
    a_r7_partner_flip: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == S_FLIP) |=> req_addr_o[FLIP_BIT] != $past(req_addr_o[FLIP_BIT]));

    // R8: done lasts one cycle
    a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |=> !done_o);

    // R9: a start seen together with done is dropped
    a_r9_start_at_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o && start_i |=> !req_valid_o);

endmodule

// File: tb/test_row_retire_seq.sv
module test_row_retire_seq;

    localparam int ADDR_W = 32;
    localparam int SYS_W  = 48;
    localparam int PFN_W  = 36;
    localparam int NCOL   = 32;

    logic              clk_i = 1'b0;
    logic              rst_ni = 1'b0;
    logic              start_i = 1'b0;
    logic [ADDR_W-1:0] err_addr_i = '0;
    logic              req_valid_o;
    logic              req_ready_i = 1'b0;
    logic [ADDR_W-1:0] req_addr_o;
    logic              rsp_valid_i = 1'b0;
    logic              rsp_fail_i = 1'b0;
    logic              rsp_online_i = 1'b0;
    logic              rsp_poisoned_i = 1'b0;
    logic [SYS_W-1:0]  rsp_sys_addr_i = '0;
    logic              ret_valid_o;
    logic              ret_ready_i = 1'b0;
    logic [PFN_W-1:0]  ret_pfn_o;
    logic              done_o;

    always #4 clk_i = ~clk_i;

    row_retire_seq i_row_retire_seq (
        .clk_i, .rst_ni, .start_i, .err_addr_i,
        .req_valid_o, .req_ready_i, .req_addr_o,
        .rsp_valid_i, .rsp_fail_i, .rsp_online_i, .rsp_poisoned_i, .rsp_sys_addr_i,
        .ret_valid_o, .ret_ready_i, .ret_pfn_o, .done_o
    );

    int          errors = 0;
    int          checks = 0;
    logic [15:0] lfsr = 16'hACE1;
    logic [31:0] run_base;
    int          req_idx;
    int          gidx = 0;
    bit          pend = 0;
    int          pend_cnt;
    longint      ret_q[$];
    bit          prev_done = 0;
    int          done_seen;
    bit          start_pending = 0;
    bit          start_at_done = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_addr(input logic [31:0] base, input int k);
        logic [31:0] a;
        a = (base & ~32'h3E) | (32'(k % NCOL) << 1);
        if (k >= NCOL) a = a ^ (32'h1 << 23);
        return a;
    endfunction

    // One cycle of the reference model: drive at the negative edge, compare outputs.
    task automatic tick();
        @(negedge clk_i);
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        start_i = start_pending;
        start_pending = 0;
        rsp_valid_i = 1'b0;
        if (pend) begin
            if (pend_cnt == 0) begin
                rsp_valid_i    = 1'b1;
                rsp_fail_i     = (gidx % 7) == 3;
                rsp_online_i   = (gidx % 5) != 2;
                rsp_poisoned_i = (gidx % 11) == 4;
                rsp_sys_addr_i = (48'(32'h5A000 + gidx) << 12) | 48'((gidx * 37) & 12'hFFF);
                if (!rsp_fail_i && rsp_online_i && !rsp_poisoned_i)
                    ret_q.push_back(longint'(rsp_sys_addr_i >> 12));
                gidx++;
                pend = 0;
            end else begin
                pend_cnt--;
            end
        end
        req_ready_i = lfsr[0] | lfsr[3];
        if (req_valid_o) begin
            chk(!pend && req_idx < 2 * NCOL, "R2 request only when expected", req_idx, 2 * NCOL);
            chk(req_addr_o == exp_addr(run_base, req_idx), req_idx >= NCOL ? "R7 partner address" : "R2 column address",
                req_addr_o, exp_addr(run_base, req_idx));
            if (req_ready_i) begin
                pend = 1;
                pend_cnt = int'(lfsr[5:4]);
                req_idx++;
            end
        end
        ret_ready_i = lfsr[1];
        if (ret_valid_o) begin
            if (ret_q.size() == 0) begin
                chk(0, "R3/R4/R5 unexpected retire", ret_pfn_o, 0);
            end else begin
                chk(longint'(ret_pfn_o) == ret_q[0], "R6 retire pfn", ret_pfn_o, ret_q[0]);
                if (ret_ready_i) void'(ret_q.pop_front());
            end
        end
        if (done_o) begin
            chk(!prev_done, "R8 single-cycle done", 1, 0);
            chk(req_idx == 2 * NCOL, "R8 done after last column", req_idx, 2 * NCOL);
            chk(ret_q.size() == 0, "R6 all retires issued", ret_q.size(), 0);
            done_seen++;
            if (start_at_done) begin
                start_i = 1'b1;
                err_addr_i = 32'hFFFF_FFFF;
                start_at_done = 0;
            end
        end
        prev_done = done_o;
    endtask

    task automatic run(input logic [31:0] base, input bit mid_start, input bit late_start);
        int cyc;
        int d0;
        run_base = base;
        req_idx = 0;
        d0 = done_seen;
        err_addr_i = base;
        start_pending = 1;
        start_at_done = late_start;
        cyc = 0;
        while (done_seen == d0 && cyc < 20000) begin
            tick();
            cyc++;
            if (mid_start && cyc == 40) begin
                err_addr_i = 32'h0055_0000;
                start_pending = 1;        // R9: busy, must be ignored
            end
        end
        if (done_seen == d0) chk(0, "R8 watchdog expired", cyc, 20000);
    endtask

    initial begin
        done_seen = 0;
        repeat (3) @(negedge clk_i);
        rst_ni = 1'b1;
        tick();
        chk(req_valid_o == 0, "R1 reset req_valid", req_valid_o, 0);
        chk(ret_valid_o == 0, "R1 reset ret_valid", ret_valid_o, 0);
        chk(done_o == 0, "R1 reset done", done_o, 0);
        repeat (3) tick();
        chk(req_valid_o == 0, "R1 idle without start", req_valid_o, 0);

        run(32'h0000_0040, 1'b0, 1'b0);
        run(32'h1280_00FF, 1'b1, 1'b1);
        for (int i = 0; i < 12; i++) begin
            tick();
            chk(req_valid_o == 0, "R9 start at done ignored", req_valid_o, 0);
        end
        run(32'hDEAD_BEEF, 1'b0, 1'b0);
        repeat (4) tick();
        chk(done_o == 0 && req_valid_o == 0, "R8 no extra done", done_o, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule